// File: doc/BRIEF.md
# Multi-Cycle Shared-Bus Processor

A small processor whose datapath is a set of registers hanging off one shared bus. Eight general registers, an operand register that feeds one side of an adder/subtractor, and a result register all read from the bus and drive onto it through a one-hot selected multiplexer. A control unit steps through each instruction with a 2-bit step counter and raises one enable per step.

There is no program counter and no instruction memory. The surrounding logic presents an instruction word on the 16-bit data input and holds `run_i` high for one cycle. The processor captures the instruction and works through it. For a move-immediate, the surrounding logic presents the immediate on the same data input in the next cycle. `done_o` marks the last step of every defined instruction.

The bus value is always visible on `bus_o`. A move of a register onto itself therefore reads that register back without changing any state.

Top module: `bus_cpu`

## Requirements
- R1: While `rst_ni` is low, every register (R0..R7, operand, result, instruction, step) clears asynchronously. After reset, `done_o` is 0, `bus_o` is 0 and every general register reads back 0.
- R2: An instruction is the upper 9 bits of `data_i`: bits [15:13] are the opcode, bits [12:10] the destination index x and bits [9:7] the source index y. Opcode 000 is move, 001 is move-immediate, 010 is add and 011 is subtract. The instruction is captured in the idle step when `run_i` is 1, and the next cycle is step 1.
- R3: In the idle step with `run_i` at 0, the processor stays idle, changes no register and keeps `done_o` at 0.
- R4: Move-immediate: in step 1, `bus_o` equals the current `data_i`, Rx loads it and `done_o` is 1.
- R5: Move: in step 1, `bus_o` equals Ry, Rx loads it and `done_o` is 1.
- R6: Add takes three steps. In step 1 the bus shows Rx. In step 2 the bus shows Ry. In step 3 the bus shows (Rx+Ry) mod 2^16, Rx loads that value and `done_o` is 1. `done_o` is 0 in steps 1 and 2.
- R7: Subtract follows the same sequence as add, and step 3 carries (Rx-Ry) mod 2^16.
- R8: `done_o` is high for exactly one cycle. The next cycle is the idle step, which accepts a new instruction at once.
- R9: Opcodes 100 to 111 write no register, keep `done_o` at 0 and return to the idle step after step 1.
- R10: When no bus source is selected (the idle step, and step 1 of an undefined opcode), `bus_o` is 0.
- R11: An instruction changes only its destination register. The other general registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Starts an instruction when the processor is idle |
| data_i | input | 16 | Instruction word or immediate operand |
| done_o | output | 1 | Last step of an instruction |
| bus_o | output | 16 | Current value of the shared bus |

## Verification
The bound checker watches the step sequencing on every cycle:
- the bus is zero and done is low while idle;
- a start leads to step 1, and staying idle keeps the processor idle;
- done is a one-cycle pulse followed by idle;
- step 3 always ends with done;
- a move-immediate routes the data input onto the bus.

Only the bench scenarios can show that the right values land in the right registers. They sweep every destination/source pair through move, add and subtract against a reference model, with wrap-around operands. They also check that undefined opcodes and idle cycles leave all eight registers untouched.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_MV  = 3'd0;
  localparam logic [OPW-1:0] OP_MVI = 3'd1;
  localparam logic [OPW-1:0] OP_ADD = 3'd2;
  localparam logic [OPW-1:0] OP_SUB = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_S1   = 2'd1,
    ST_S2   = 2'd2,
    ST_S3   = 2'd3
  } step_e;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREG-1:0]          wr_i,
  input  logic [DW-1:0]            bus_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_o[i] <= '0;
      else if (wr_i[i]) regs_o[i] <= bus_i;
    end
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] bus_i,
  input  logic          a_load_i,
  input  logic          g_load_i,
  input  logic          sub_i,
  output logic [DW-1:0] g_o
);
  logic [DW-1:0] a_q;
  logic [DW-1:0] sum;

  // wraps modulo 2^DW, no flags
  assign sum = sub_i ? (a_q - bus_i) : (a_q + bus_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      g_o <= '0;
    end else begin
      if (a_load_i) a_q <= bus_i;
      if (g_load_i) g_o <= sum;
    end
  end
endmodule

// File: rtl/cpu_bus_mux.sv
module cpu_bus_mux #(
  parameter int DW   = 16,
  parameter int NSRC = 10
) (
  input  logic [NSRC-1:0]          sel_i,
  input  logic [NSRC-1:0][DW-1:0]  src_i,
  output logic [DW-1:0]            bus_o
);
  // AND-OR over one-hot select; zero when nothing selected
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NSRC; i++) bus_o |= {DW{sel_i[i]}} & src_i[i];
  end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import cpu_pkg::*;
#(
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG),
  parameter int IRW  = OPW + 2 * RW,
  parameter int NSRC = NREG + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [IRW-1:0]    instr_i,
  output logic [NSRC-1:0]   sel_o,
  output logic [NREG-1:0]   wr_o,
  output logic              a_load_o,
  output logic              g_load_o,
  output logic              sub_o,
  output logic              done_o,
  output step_e             step_o,
  output logic [OPW-1:0]    op_o
);
  localparam int SEL_G   = NREG;
  localparam int SEL_DIN = NREG + 1;

  logic [IRW-1:0]  ir_q;
  step_e           step_d;
  logic            ir_load;
  logic [RW-1:0]   fx, fy;
  logic [NREG-1:0] x_oh, y_oh;

  assign op_o = ir_q[IRW-1 -: OPW];
  assign fx   = ir_q[2*RW-1 -: RW];
  assign fy   = ir_q[RW-1:0];
  assign x_oh = {{(NREG-1){1'b0}}, 1'b1} << fx;
  assign y_oh = {{(NREG-1){1'b0}}, 1'b1} << fy;

  always_comb begin
    step_d   = step_o;
    ir_load  = 1'b0;
    sel_o    = '0;
    wr_o     = '0;
    a_load_o = 1'b0;
    g_load_o = 1'b0;
    sub_o    = 1'b0;
    done_o   = 1'b0;
    unique case (step_o)
      ST_IDLE: begin
        if (run_i) begin
          ir_load = 1'b1;
          step_d  = ST_S1;
        end
      end
      ST_S1: begin
        step_d = ST_IDLE;
        case (op_o)
          OP_MV: begin
            sel_o  = {2'b00, y_oh};
            wr_o   = x_oh;
            done_o = 1'b1;
          end
          OP_MVI: begin
            sel_o[SEL_DIN] = 1'b1;
            wr_o   = x_oh;
            done_o = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            sel_o    = {2'b00, x_oh};
            a_load_o = 1'b1;
            step_d   = ST_S2;
          end
          default: ;  // undefined: back to idle, nothing written
        endcase
      end
      ST_S2: begin
        sel_o    = {2'b00, y_oh};
        g_load_o = 1'b1;
        sub_o    = (op_o == OP_SUB);
        step_d   = ST_S3;
      end
      ST_S3: begin
        sel_o[SEL_G] = 1'b1;
        wr_o   = x_oh;
        done_o = 1'b1;
        step_d = ST_IDLE;
      end
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_o <= ST_IDLE;
      ir_q   <= '0;
    end else begin
      step_o <= step_d;
      if (ir_load) ir_q <= instr_i;
    end
  end
endmodule

// File: rtl/bus_cpu.sv
module bus_cpu
  import cpu_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic [DW-1:0] bus_o
);
  localparam int RW   = $clog2(NREG);
  localparam int IRW  = OPW + 2 * RW;
  localparam int NSRC = NREG + 2;

  logic [NSRC-1:0]         sel;
  logic [NREG-1:0]         wr;
  logic                    a_load, g_load, sub;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           g_q;
  logic [NSRC-1:0][DW-1:0] srcs;
  step_e                   step_q;
  logic [OPW-1:0]          ir_op;

  assign srcs = {data_i, g_q, regs};

  cpu_ctrl #(.NREG(NREG)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .instr_i  (data_i[DW-1 -: IRW]),
    .sel_o    (sel),
    .wr_o     (wr),
    .a_load_o (a_load),
    .g_load_o (g_load),
    .sub_o    (sub),
    .done_o   (done_o),
    .step_o   (step_q),
    .op_o     (ir_op)
  );

  cpu_regfile #(.DW(DW), .NREG(NREG)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .bus_i  (bus_o),
    .regs_o (regs)
  );

  cpu_alu #(.DW(DW)) u_alu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    (bus_o),
    .a_load_i (a_load),
    .g_load_i (g_load),
    .sub_i    (sub),
    .g_o      (g_q)
  );

  cpu_bus_mux #(.DW(DW), .NSRC(NSRC)) u_mux (
    .sel_i (sel),
    .src_i (srcs),
    .bus_o (bus_o)
  );
endmodule

// File: rtl/cpu_chk.sv
module cpu_chk
  import cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic [DW-1:0]  data_i,
  input logic           done_o,
  input logic [DW-1:0]  bus_o,
  input step_e          step_i,
  input logic [OPW-1:0] op_i
);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i == ST_IDLE |-> (bus_o == '0) && !done_o);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_IDLE) && !run_i |=> step_i == ST_IDLE);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_IDLE) && run_i |=> step_i == ST_S1);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && (step_i == ST_IDLE));

  assert_arith_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i == ST_S3 |-> done_o);

  assert_mvi_route_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_S1) && (op_i == OP_MVI) |-> (bus_o == data_i) && done_o);

  assert_undef_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_S1) && op_i[2] |-> !done_o && (bus_o == '0));
endmodule

bind bus_cpu cpu_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run_i),
  .data_i (data_i),
  .done_o (done_o),
  .bus_o  (bus_o),
  .step_i (step_q),
  .op_i   (ir_op)
);

// File: tb/sim_bus_cpu.sv
`timescale 1ns/1ps
module sim_bus_cpu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        done_o;
  logic [15:0] bus_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] model [8];

  always #4 clk_i = ~clk_i;

  bus_cpu u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [2:0] op, input logic [2:0] x, input logic [2:0] y);
    return {op, x, y, 7'b0};
  endfunction

  // issue in idle step; check idle outputs
  task automatic issue(input logic [15:0] w);
    @(negedge clk_i); run_i = 1'b1; data_i = w; #1;
    chk("R10 idle bus", bus_o, 16'h0);
    chk("R8 idle done", {15'b0, done_o}, 16'h0);
  endtask

  task automatic rd(input int r, input string tag);
    issue(word(3'b000, 3'(r), 3'(r)));
    @(negedge clk_i); run_i = 1'b0; data_i = 16'hDEAD; #1;
    chk(tag, bus_o, model[r]);
    chk("R5 read done", {15'b0, done_o}, 16'h1);
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < 8; r++) rd(r, tag);
  endtask

  task automatic mvi(input int x, input logic [15:0] v);
    issue(word(3'b001, 3'(x), 3'(7 - x)));
    @(negedge clk_i); run_i = 1'b0; data_i = v; #1;
    chk("R4 mvi bus", bus_o, v);
    chk("R4 mvi done", {15'b0, done_o}, 16'h1);
    model[x] = v;
  endtask

  task automatic mv(input int x, input int y);
    issue(word(3'b000, 3'(x), 3'(y)));
    @(negedge clk_i); run_i = 1'b0; data_i = 16'h0; #1;
    chk("R5 mv bus", bus_o, model[y]);
    chk("R5 mv done", {15'b0, done_o}, 16'h1);
    model[x] = model[y];
  endtask

  task automatic arith(input bit is_sub, input int x, input int y);
    logic [15:0] res;
    res = is_sub ? model[x] - model[y] : model[x] + model[y];
    issue(word(is_sub ? 3'b011 : 3'b010, 3'(x), 3'(y)));
    @(negedge clk_i); run_i = 1'b0; data_i = 16'h0; #1;
    chk("R6 step1 bus", bus_o, model[x]);
    chk("R6 step1 done", {15'b0, done_o}, 16'h0);
    @(negedge clk_i); #1;
    chk("R6 step2 bus", bus_o, model[y]);
    chk("R6 step2 done", {15'b0, done_o}, 16'h0);
    @(negedge clk_i); #1;
    chk(is_sub ? "R7 sub result" : "R6 add result", bus_o, res);
    chk("R6 step3 done", {15'b0, done_o}, 16'h1);
    model[x] = res;
  endtask

  task automatic fill(input int seed);
    for (int x = 0; x < 8; x++) mvi(x, 16'(x * 16'h1357 + seed * 16'h2F1D + 16'hF0F0));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset bus", bus_o, 16'h0);
    chk("R1 reset done", {15'b0, done_o}, 16'h0);
    rst_ni = 1'b1;
    read_all("R1 reset regs");

    // R3: idle with run low, inputs wiggling
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); run_i = 1'b0; data_i = word(3'b001, 3'(k), 3'(k)); #1;
      chk("R3 idle done", {15'b0, done_o}, 16'h0);
      chk("R3 idle bus", bus_o, 16'h0);
    end
    read_all("R3 regs unchanged");

    fill(1);
    read_all("R11 mvi regs");

    // move sweep, every pair
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        mv(x, y);
        rd(x, "R5 dest");
      end
    read_all("R11 after mv");

    // add / subtract sweeps with wrap-prone operands
    for (int s = 0; s < 2; s++) begin
      fill(s + 2);
      mvi(0, 16'hFFFF);
      mvi(1, 16'h0001);
      for (int x = 0; x < 8; x++)
        for (int y = 0; y < 8; y++) begin
          arith(s[0], x, y);
          rd(x, s ? "R7 dest" : "R6 dest");
        end
      read_all("R11 after arith");
    end

    // explicit wrap cases
    mvi(2, 16'hFFFF); mvi(3, 16'h0002);
    arith(1'b0, 2, 3);
    chk("R6 wrap add", model[2], 16'h0001);
    mvi(4, 16'h0000); mvi(5, 16'h0001);
    arith(1'b1, 4, 5);
    chk("R7 wrap sub", model[4], 16'hFFFF);

    // undefined opcodes 100..111
    for (int op = 4; op < 8; op++) begin
      issue(word(3'(op), 3'(op), 3'(op - 4)));
      @(negedge clk_i); run_i = 1'b0; data_i = 16'h1234; #1;
      chk("R9 undef done", {15'b0, done_o}, 16'h0);
      chk("R10 undef bus", bus_o, 16'h0);
      rd(op, "R9 back to idle");
    end
    read_all("R9 regs unchanged");

    // back-to-back: instruction right after done
    mvi(6, 16'hA5A5);
    mv(7, 6);
    chk("R8 back-to-back", model[7], 16'hA5A5);
    rd(7, "R8 dest");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule